// File: doc/BRIEF.md
# Buffered-Program Command Sequencer for a Parallel NOR Flash

This block sits behind a host bus and interprets single bus write cycles as the buffered-program command of a parallel NOR flash. A program operation has four parts. A setup cycle carries the command 0xE8 and selects a 128-byte page. A count cycle carries N, which is one less than the number of elements to load. N+1 data cycles follow, each placing an element at its offset inside the page. The last cycle is a confirm. The loaded elements live in an internal write buffer and the storage array is not touched until a valid confirm arrives.

After a confirm, the buffer is copied into the array at one buffer slot per clock. Only the slots loaded during the sequence are copied. While this copy runs, the block reports itself busy and ignores the bus. Any of the following ends the operation at once: a wrong page, an oversized count, a read-only device, or a foreign value in the confirm slot. The array is left as it was. A sticky error flag in the status byte records each of these errors except the foreign confirm value. Only a clear-status command resets that flag.

Top module: `flash_wbuf_seq`

## Requirements
- R1: After reset, `status` reads 0x80 (bit 7 ready, bit 4 error clear), and every array location reads 0xFF through `rd_data`.
- R2: In idle, a write whose low 8 bits are 0xE8 starts a program sequence and latches the page, which is `wr_addr[8:7]` by default. `status` stays 0x80.
- R3: The count cycle carries N in `wr_data`. If N is larger than the buffer depth minus one (127 for 8-bit elements), or if the cycle's page differs from the latched page, status bit 4 is set and the block returns to idle.
- R4: Exactly N+1 data cycles follow. Each one stores `wr_data` at offset `wr_addr[6:0]` of the buffer. A data cycle addressed outside the latched page sets status bit 4 and returns the block to idle.
- R5: A confirm value of 0xD0 in the slot after the last data cycle copies every loaded element into the array. Elements of the page that were not loaded keep their old contents.
- R6: Any other value in the confirm slot discards the buffer, leaves the array unchanged, leaves status bit 4 unchanged, and returns the block to idle.
- R7: During the copy, status bit 7 reads 0 and `rd_data` returns the status byte instead of array data. The copy lasts 128 cycles. Afterwards bit 7 reads 1 again.
- R8: Bus writes issued during the copy are ignored. They start no new sequence and change no array location.
- R9: When `lock_ro` is 1 at the confirm, status bit 4 is set, the array is unchanged, and the block returns to idle.
- R10: In idle, 0x50 clears status bit 4. 0xFF and any other non-setup value leave the status and the array unchanged.
- R11: Status bit 4 is sticky. A later successful program does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One host write cycle this clock |
| wr_addr | input | ADDR_W (9) | Element address of the write |
| wr_data | input | DATA_W (8) | Command, count or data element |
| lock_ro | input | 1 | Device is read-only; a confirm then fails |
| rd_addr | input | ADDR_W (9) | Element address to read |
| rd_data | output | DATA_W (8) | Array data, or the status byte while busy |
| status | output | 8 | Bit 7 ready, bit 4 program error, others 0 |

## Verification
The embedded properties check the sequencer's transitions on every cycle:
- an oversized count or a page mismatch ends in idle with the error set;
- a proper confirm enters the copy and a foreign confirm returns to idle with the error unchanged;
- the latched page stays fixed through the copy;
- the error flag holds until a clear command.

Only the bench scenarios can show the data-path results. These are:
- the array contents after a full-page or partial program;
- the untouched locations after an abort, a read-only confirm or an off-page data cycle;
- the 128-cycle busy window, during which writes leave no trace.

// File: rtl/fwb_pkg.sv
// Package: shared state encoding and command codes for the buffered-program sequencer.
package fwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_DATA,
        ST_CONFIRM,
        ST_COMMIT
    } seq_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLRSTS  = 8'h50;
endpackage

// File: rtl/fwb_ctrl.sv
// fwb_ctrl: command state machine of the buffered program.
// Walks the sequence setup -> count -> data x (N+1) -> confirm -> commit.
// It owns the sticky error flag, the latched page and the commit slot index.
// Assumes one host write per wr_en cycle and DATA_W > OFS_W.
module fwb_ctrl
    import fwb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9,
    parameter int OFS_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    lock_ro,
    output logic                    buf_clr,
    output logic                    buf_we,
    output logic [OFS_W-1:0]        buf_ofs,
    output logic                    commit_en,
    output logic [OFS_W-1:0]        commit_idx,
    output logic [ADDR_W-OFS_W-1:0] page,
    output logic                    busy,
    output logic [7:0]              status
);
    localparam int PG_W = ADDR_W - OFS_W;

    seq_state_e        state;
    logic [PG_W-1:0]   page_q;
    logic [OFS_W-1:0]  remain;
    logic [OFS_W-1:0]  idx;
    logic              err;

    logic [7:0]        cmd;
    logic              page_ok;
    logic              count_ok;

    // Decode the current write: its command byte, whether it hits the page, whether the count fits.
    always_comb begin
        cmd      = wr_data[7:0];
        page_ok  = (wr_addr[ADDR_W-1:OFS_W] == page_q);
        count_ok = ((wr_data >> OFS_W) == '0);
    end

    // Sequence state, page latch, element countdown, commit index and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            page_q <= '0;
            remain <= '0;
            idx    <= '0;
            err    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_en) begin
                        if (cmd == CMD_SETUP) begin
                            page_q <= wr_addr[ADDR_W-1:OFS_W];
                            state  <= ST_COUNT;
                        end else if (cmd == CMD_CLRSTS) begin
                            err <= 1'b0;
                        end
                    end
                end
                ST_COUNT: begin
                    if (wr_en) begin
                        if (!page_ok || !count_ok) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            remain <= wr_data[OFS_W-1:0];
                            state  <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (wr_en) begin
                        if (!page_ok) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else if (remain == '0) begin
                            state <= ST_CONFIRM;
                        end else begin
                            remain <= remain - 1'b1;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (wr_en) begin
                        if (cmd != CMD_CONFIRM) begin
                            state <= ST_IDLE;
                        end else if (lock_ro) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            idx   <= '0;
                            state <= ST_COMMIT;
                        end
                    end
                end
                ST_COMMIT: begin
                    idx <= idx + 1'b1;
                    if (&idx) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the buffer and array strobes and assemble the status byte.
    always_comb begin
        buf_clr    = (state == ST_IDLE) && wr_en && (cmd == CMD_SETUP);
        buf_we     = (state == ST_DATA) && wr_en && page_ok;
        buf_ofs    = wr_addr[OFS_W-1:0];
        commit_en  = (state == ST_COMMIT);
        commit_idx = idx;
        page       = page_q;
        busy       = (state == ST_COMMIT);
        status     = {~busy, 2'b00, err, 4'b0000};
    end

    a_r3_count_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && wr_en && !count_ok) |=> (state == ST_IDLE && err));

    a_r4_page_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && wr_en && !page_ok) |=> (state == ST_IDLE && err));

    a_r5_confirm_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIRM && wr_en && cmd == CMD_CONFIRM && !lock_ro) |=> (state == ST_COMMIT));

    a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIRM && wr_en && cmd != CMD_CONFIRM) |=> (state == ST_IDLE && $stable(err)));

    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> $stable(page_q));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && cmd == CMD_CLRSTS) |=> !err);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(state == ST_IDLE && wr_en && cmd == CMD_CLRSTS)) |=> err);
endmodule

// File: rtl/fwb_buffer.sv
// fwb_buffer: page-sized write buffer with one valid bit per slot.
// The valid bits are cleared at setup so that a commit copies only the slots that were loaded.
// Assumes that clr and we are never active in the same cycle.
module fwb_buffer #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [OFS_W-1:0]  wofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFS_W-1:0]  rofs,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int DEPTH = 1 << OFS_W;

    logic [DATA_W-1:0] slot [DEPTH];
    logic [DEPTH-1:0]  valid;

    // Store a data element into its slot.
    always_ff @(posedge clk) begin
        if (we) slot[wofs] <= wdata;
    end

    // Track which slots hold loaded data since the last setup.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid <= '0;
        else if (we)       valid[wofs] <= 1'b1;
    end

    // Present one slot to the commit path.
    always_comb begin
        rdata  = slot[rofs];
        rvalid = valid[rofs];
    end
endmodule

// File: rtl/fwb_array.sv
// fwb_array: small storage array with one write port and one combinational read port.
// Reset fills it with the erased value (all ones).
module fwb_array #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Erase on reset, else take one committed element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read of one element.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/flash_wbuf_seq.sv
// flash_wbuf_seq: top level of the buffered-program sequencer.
// It connects the command FSM, the write buffer and the storage array.
// While a commit runs, the read port returns the status byte.
// Assumes DATA_W is 8, 16 or 32 bits and the buffer is 128 bytes, aligned to its own size.
module flash_wbuf_seq #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 9,
    parameter int BUF_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock_ro,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);
    localparam int ELEMS = BUF_BYTES / (DATA_W / 8);
    localparam int OFS_W = $clog2(ELEMS);
    localparam int PG_W  = ADDR_W - OFS_W;

    logic              buf_clr, buf_we, commit_en, busy, buf_rvalid;
    logic [OFS_W-1:0]  buf_ofs, commit_idx;
    logic [PG_W-1:0]   page;
    logic [DATA_W-1:0] buf_rdata, arr_rdata;

    fwb_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lock_ro(lock_ro), .buf_clr(buf_clr), .buf_we(buf_we), .buf_ofs(buf_ofs),
        .commit_en(commit_en), .commit_idx(commit_idx), .page(page), .busy(busy),
        .status(status)
    );

    fwb_buffer #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .wofs(buf_ofs),
        .wdata(wr_data), .rofs(commit_idx), .rdata(buf_rdata), .rvalid(buf_rvalid)
    );

    fwb_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(commit_en && buf_rvalid),
        .waddr({page, commit_idx}), .wdata(buf_rdata), .raddr(rd_addr), .rdata(arr_rdata)
    );

    // Reads see the status byte while busy and array data otherwise.
    always_comb rd_data = busy ? {{(DATA_W-8){1'b0}}, status} : arr_rdata;
endmodule

// File: tb/tb_flash_wbuf_seq.sv
// Scoreboard bench: driver tasks push expectations, a monitor pops and compares.
module tb_flash_wbuf_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       lock_ro = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    int pending = 0;
    bit done = 1'b0;

    bit    q_kind [$];
    logic [8:0] q_addr [$];
    logic [7:0] q_exp [$];
    string q_req [$];

    always #5 clk = ~clk;

    flash_wbuf_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lock_ro(lock_ro), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
    );

    task automatic bus_wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_sts(input logic [7:0] e, input string req);
        q_kind.push_back(1'b0); q_addr.push_back('0); q_exp.push_back(e); q_req.push_back(req);
        pending++;
        wait (pending == 0);
    endtask

    task automatic expect_rd(input logic [8:0] a, input logic [7:0] e, input string req);
        q_kind.push_back(1'b1); q_addr.push_back(a); q_exp.push_back(e); q_req.push_back(req);
        pending++;
        wait (pending == 0);
    endtask

    // Monitor: one expectation per cycle, sampled well after the edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_exp.size() > 0) begin
                bit k;
                logic [7:0] e, act;
                string r;
                k = q_kind.pop_front();
                rd_addr = q_addr.pop_front();
                e = q_exp.pop_front();
                r = q_req.pop_front();
                #1;
                act = k ? rd_data : status;
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: %s actual %h expected %h", r, k ? "rd_data" : "status", act, e);
                end
                pending--;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_sts(8'h80, "R1");
        expect_rd(9'd0,   8'hFF, "R1");
        expect_rd(9'd300, 8'hFF, "R1");

        // R2, R4, R5, R7, R8: partial program of page 1
        bus_wr(9'd128, 8'hE8);
        expect_sts(8'h80, "R2");
        bus_wr(9'd128, 8'd3);
        bus_wr(9'd130, 8'hA0);
        bus_wr(9'd131, 8'hA1);
        bus_wr(9'd132, 8'hA2);
        bus_wr(9'd133, 8'hA3);
        bus_wr(9'd128, 8'hD0);
        expect_sts(8'h00, "R7");
        expect_rd(9'd130, 8'h00, "R7");
        bus_wr(9'd5, 8'hE8);   // ignored while busy
        bus_wr(9'd5, 8'd0);
        bus_wr(9'd5, 8'h55);
        bus_wr(9'd5, 8'hD0);
        repeat (140) @(negedge clk);
        expect_sts(8'h80, "R7");
        expect_rd(9'd130, 8'hA0, "R5");
        expect_rd(9'd133, 8'hA3, "R5");
        expect_rd(9'd129, 8'hFF, "R5");
        expect_rd(9'd5,   8'hFF, "R8");

        // R6: foreign confirm value aborts
        bus_wr(9'd0, 8'hE8);
        bus_wr(9'd0, 8'd1);
        bus_wr(9'd0, 8'h10);
        bus_wr(9'd1, 8'h11);
        bus_wr(9'd0, 8'h70);
        expect_sts(8'h80, "R6");
        expect_rd(9'd0, 8'hFF, "R6");
        expect_rd(9'd1, 8'hFF, "R6");

        // R10: 0xFF in idle has no effect
        bus_wr(9'd0, 8'hFF);
        expect_sts(8'h80, "R10");
        expect_rd(9'd0, 8'hFF, "R10");

        // R3: oversized count
        bus_wr(9'd0, 8'hE8);
        bus_wr(9'd0, 8'h80);
        expect_sts(8'h90, "R3");
        bus_wr(9'd0, 8'h50);
        expect_sts(8'h80, "R10");

        // R3: count cycle on another page
        bus_wr(9'd256, 8'hE8);
        bus_wr(9'd0, 8'd0);
        expect_sts(8'h90, "R3");
        bus_wr(9'd0, 8'h50);

        // R4: data cycle off the latched page
        bus_wr(9'd256, 8'hE8);
        bus_wr(9'd256, 8'd0);
        bus_wr(9'd16, 8'h33);
        expect_sts(8'h90, "R4");
        bus_wr(9'd16, 8'hD0);
        expect_rd(9'd16, 8'hFF, "R4");
        bus_wr(9'd0, 8'h50);
        expect_sts(8'h80, "R10");

        // R9: read-only confirm fails
        lock_ro = 1'b1;
        bus_wr(9'd384, 8'hE8);
        bus_wr(9'd384, 8'd0);
        bus_wr(9'd384, 8'h77);
        bus_wr(9'd384, 8'hD0);
        expect_sts(8'h90, "R9");
        expect_rd(9'd384, 8'hFF, "R9");
        lock_ro = 1'b0;

        // R4, R11: full-page program with the error flag still set
        bus_wr(9'd384, 8'hE8);
        bus_wr(9'd384, 8'h7F);
        for (int i = 0; i < 128; i++) bus_wr(9'(384 + i), 8'(i) ^ 8'h5A);
        bus_wr(9'd384, 8'hD0);
        expect_sts(8'h10, "R7");
        repeat (140) @(negedge clk);
        expect_sts(8'h90, "R11");
        expect_rd(9'd384, 8'h5A, "R4");
        expect_rd(9'd447, 8'h65, "R4");
        expect_rd(9'd511, 8'h25, "R4");
        expect_rd(9'd200, 8'hFF, "R5");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule